// File: doc/BRIEF.md
# Split-Half 64-Bit Bitwise and Shift Unit

This unit operates on 64-bit integers that travel as two 32-bit halves, a low word and a high word. Each request carries an 8-bit operation code, the two halves of source 0, and a second operand. The logic operations treat source 1 as another pair of halves and work on each half with no path between the halves.

For shifts, only the low word of source 1 is used, as an unsigned 32-bit count. The shifted 64-bit result is built from 32-bit half shifters. An explicit splice carries the bits that cross the half boundary. Counts of zero, one full half, and the full word or more are decoded as corner cases.

A request is taken when `in_valid` is high. The result is registered and appears with `out_valid` one cycle later. A code outside the supported set flags an error.

Top module: `halfpair_bitshift_unit`

## Requirements
- R1: While reset is asserted, and after it, until the first request completes, `out_valid`, `out_err`, `out_lo` and `out_hi` are all zero.
- R2: `out_valid` is high exactly in the cycle after a cycle in which `in_valid` was high.
- R3: The logic operations work half by half, with no carry between the halves:
  - Code 0x04 gives the AND of source 0 and source 1.
  - Code 0x05 gives the OR of the two sources.
  - Code 0x06 gives the XOR of the two sources.
- R4: Code 0x01 inverts both halves of source 0, and code 0x00 copies source 0 unchanged. Both give the same result whatever source 1 holds.
- R5: Code 0x10 is a logical left shift of the 64-bit pair by the count in `b_lo`. Bits leaving the low half enter the high half. Code 0x02, arithmetic left, gives the same result as 0x10.
- R6: Code 0x11 is a logical right shift of the pair by the count in `b_lo`. Bits leaving the high half enter the low half, and the vacated bits are zero.
- R7: Code 0x03 is an arithmetic right shift. The vacated bits are filled with bit 63 of the pair, which is bit 31 of `a_hi`.
- R8: A count of 0 returns source 0 unchanged for every shift code. A count of exactly 32 moves one whole half into the other:
  - Left shifts give a low half of zero and a high half equal to the old low half.
  - Right shifts give a low half equal to the old high half, with the high half set to the fill.
- R9: A count of 64 or more gives zero for codes 0x02, 0x10 and 0x11. For code 0x03 it gives all bits equal to bit 63. All 32 bits of the count are significant.
- R10: For shift codes, `b_hi` has no effect on the result.
- R11: Any code other than 0x00, 0x01, 0x02, 0x03, 0x04, 0x05, 0x06, 0x10 and 0x11 gives `out_err` high with both result halves zero. Supported codes give `out_err` low. `out_err` is only high together with `out_valid`.
- R12: In a cycle after one without `in_valid`, `out_lo` and `out_hi` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| in_op | input | 8 | Operation code |
| a_lo | input | 32 | Source 0, low half |
| a_hi | input | 32 | Source 0, high half |
| b_lo | input | 32 | Source 1 low half, or shift count for shifts |
| b_hi | input | 32 | Source 1 high half, unused by shifts |
| out_valid | output | 1 | Result present |
| out_lo | output | 32 | Result, low half |
| out_hi | output | 32 | Result, high half |
| out_err | output | 1 | Unsupported operation code |

## Verification
The bench builds the unit with its default parameters: 32-bit halves and a 32-bit count. At that size every branch of the splice can be reached with a few directed counts: 0, 1, 31, 32, 33, 63, 64 and 0xFFFF_FFFF. Each of these counts is applied to every shift code, with source values whose bit 63 is set and whose bit 63 is clear. This exposes a wrong fill, a wrong boundary crossing, or a count truncated to its low bits.

// File: rtl/hpb_pkg.sv
package hpb_pkg;
   localparam int OPC_W = 8;

   typedef enum logic [OPC_W-1:0] {
      OPC_PASS = 8'h00,
      OPC_INV  = 8'h01,
      OPC_ASL  = 8'h02,
      OPC_ASR  = 8'h03,
      OPC_AND  = 8'h04,
      OPC_OR   = 8'h05,
      OPC_XOR  = 8'h06,
      OPC_LSL  = 8'h10,
      OPC_LSR  = 8'h11
   } opcode_e;

   function automatic logic is_logic_op(input logic [OPC_W-1:0] c);
      return (c == OPC_PASS) || (c == OPC_INV) || (c == OPC_AND) ||
             (c == OPC_OR) || (c == OPC_XOR);
   endfunction

   function automatic logic is_shift_op(input logic [OPC_W-1:0] c);
      return (c == OPC_ASL) || (c == OPC_ASR) || (c == OPC_LSL) || (c == OPC_LSR);
   endfunction
endpackage

// File: rtl/hpb_logic_lane.sv
module hpb_logic_lane #(
   parameter int W = 32
) (
   input  logic [hpb_pkg::OPC_W-1:0] op,
   input  logic [W-1:0]              x,
   input  logic [W-1:0]              y,
   output logic [W-1:0]              r
);
   always_comb begin
      unique case (op)
         hpb_pkg::OPC_PASS: r = x;
         hpb_pkg::OPC_INV:  r = ~x;
         hpb_pkg::OPC_AND:  r = x & y;
         hpb_pkg::OPC_OR:   r = x | y;
         hpb_pkg::OPC_XOR:  r = x ^ y;
         default:           r = '0;
      endcase
   end
endmodule

// File: rtl/hpb_shift_splice.sv
module hpb_shift_splice #(
   parameter int W     = 32,
   parameter int CNT_W = 32
) (
   input  logic [W-1:0]     lo,
   input  logic [W-1:0]     hi,
   input  logic [CNT_W-1:0] cnt,
   input  logic             go_left,
   input  logic             arith,
   output logic [W-1:0]     r_lo,
   output logic [W-1:0]     r_hi
);
   localparam int SH_W = $clog2(W);
   localparam logic [CNT_W-1:0] HALF_C = CNT_W'(W);
   localparam logic [CNT_W-1:0] FULL_C = CNT_W'(2 * W);

   logic [W-1:0]    fill;
   logic [SH_W-1:0] k;
   logic [SH_W-1:0] inv;

   assign fill = (arith && !go_left) ? {W{hi[W-1]}} : '0;
   // k is the count modulo W; inv = W - k, valid when k is nonzero
   assign k    = cnt[SH_W-1:0];
   assign inv  = SH_W'(W) - k;

   always_comb begin
      r_lo = lo;
      r_hi = hi;
      if (cnt >= FULL_C) begin
         r_lo = go_left ? '0 : fill;
         r_hi = go_left ? '0 : fill;
      end else if (cnt == '0) begin
         r_lo = lo;
         r_hi = hi;
      end else if (cnt < HALF_C) begin
         if (go_left) begin
            r_lo = lo << k;
            r_hi = (hi << k) | (lo >> inv);
         end else begin
            r_lo = (lo >> k) | (hi << inv);
            r_hi = (hi >> k) | (fill << inv);
         end
      end else if (cnt == HALF_C) begin
         r_lo = go_left ? '0 : hi;
         r_hi = go_left ? lo : fill;
      end else begin
         if (go_left) begin
            r_lo = '0;
            r_hi = lo << k;
         end else begin
            r_lo = (hi >> k) | (fill << inv);
            r_hi = fill;
         end
      end
   end
endmodule

// File: rtl/halfpair_bitshift_unit.sv
module halfpair_bitshift_unit #(
   parameter int HALF_W = 32,
   parameter int CNT_W  = 32
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   input  logic [hpb_pkg::OPC_W-1:0] in_op,
   input  logic [HALF_W-1:0]         a_lo,
   input  logic [HALF_W-1:0]         a_hi,
   input  logic [CNT_W-1:0]          b_lo,
   input  logic [HALF_W-1:0]         b_hi,
   output logic                      out_valid,
   output logic [HALF_W-1:0]         out_lo,
   output logic [HALF_W-1:0]         out_hi,
   output logic                      out_err
);
   localparam int NUM_HALVES = 2;

   if (HALF_W < 2 || (HALF_W & (HALF_W - 1)) != 0) begin : g_bad_half
      $error("HALF_W must be a power of two of at least 2");
   end
   if (CNT_W != HALF_W) begin : g_bad_cnt
      $error("CNT_W must equal HALF_W: the count rides in the low half of source 1");
   end

   logic [NUM_HALVES-1:0][HALF_W-1:0] a_pr, b_pr, lg_pr;
   logic [HALF_W-1:0] sh_lo, sh_hi;
   logic              is_sh, is_lg, go_left, arith;
   logic [HALF_W-1:0] nx_lo, nx_hi;

   assign a_pr = {a_hi, a_lo};
   assign b_pr = {b_hi, HALF_W'(b_lo)};

   for (genvar g = 0; g < NUM_HALVES; g++) begin : g_lane
      hpb_logic_lane #(.W(HALF_W)) u_lane (
         .op (in_op),
         .x  (a_pr[g]),
         .y  (b_pr[g]),
         .r  (lg_pr[g])
      );
   end

   assign go_left = (in_op == hpb_pkg::OPC_ASL) || (in_op == hpb_pkg::OPC_LSL);
   assign arith   = (in_op == hpb_pkg::OPC_ASR);

   hpb_shift_splice #(.W(HALF_W), .CNT_W(CNT_W)) u_shift (
      .lo      (a_lo),
      .hi      (a_hi),
      .cnt     (b_lo),
      .go_left (go_left),
      .arith   (arith),
      .r_lo    (sh_lo),
      .r_hi    (sh_hi)
   );

   assign is_sh = hpb_pkg::is_shift_op(in_op);
   assign is_lg = hpb_pkg::is_logic_op(in_op);

   always_comb begin
      if (is_sh) begin
         nx_lo = sh_lo;
         nx_hi = sh_hi;
      end else if (is_lg) begin
         nx_lo = lg_pr[0];
         nx_hi = lg_pr[1];
      end else begin
         nx_lo = '0;
         nx_hi = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_err   <= 1'b0;
         out_lo    <= '0;
         out_hi    <= '0;
      end else begin
         out_valid <= in_valid;
         out_err   <= in_valid && !is_sh && !is_lg;
         if (in_valid) begin
            out_lo <= nx_lo;
            out_hi <= nx_hi;
         end
      end
   end
endmodule

// File: rtl/hpb_checker.sv
module hpb_checker #(
   parameter int HALF_W = 32,
   parameter int CNT_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [7:0]        in_op,
   input logic [HALF_W-1:0] a_lo,
   input logic [HALF_W-1:0] a_hi,
   input logic [CNT_W-1:0]  b_lo,
   input logic [HALF_W-1:0] b_hi,
   input logic              out_valid,
   input logic [HALF_W-1:0] out_lo,
   input logic [HALF_W-1:0] out_hi,
   input logic              out_err
);
   logic shift_req;
   assign shift_req = (in_op == 8'h02) || (in_op == 8'h03) ||
                      (in_op == 8'h10) || (in_op == 8'h11);

   a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r2_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   a_r11_err_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
      out_err |-> out_valid);
   a_r11_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
      out_err |-> (out_lo == '0 && out_hi == '0));
   a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_lo) && $stable(out_hi)));
   a_r3_xor_halves: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op == 8'h06) |=>
      (out_lo == ($past(a_lo) ^ HALF_W'($past(b_lo))) && out_hi == ($past(a_hi) ^ $past(b_hi))));
   a_r4_invert: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op == 8'h01) |=> (out_lo == ~$past(a_lo) && out_hi == ~$past(a_hi)));
   a_r8_count_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && shift_req && b_lo == '0) |=>
      (out_lo == $past(a_lo) && out_hi == $past(a_hi) && !out_err));
endmodule

bind halfpair_bitshift_unit hpb_checker #(.HALF_W(HALF_W), .CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_op     (in_op),
   .a_lo      (a_lo),
   .a_hi      (a_hi),
   .b_lo      (b_lo),
   .b_hi      (b_hi),
   .out_valid (out_valid),
   .out_lo    (out_lo),
   .out_hi    (out_hi),
   .out_err   (out_err)
);

// File: tb/halfpair_bitshift_unit_test.sv
module halfpair_bitshift_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_op = 8'h00;
   logic [31:0] a_lo = '0, a_hi = '0, b_lo = '0, b_hi = '0;
   logic        out_valid, out_err;
   logic [31:0] out_lo, out_hi;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   halfpair_bitshift_unit uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
      .a_lo(a_lo), .a_hi(a_hi), .b_lo(b_lo), .b_hi(b_hi),
      .out_valid(out_valid), .out_lo(out_lo), .out_hi(out_hi), .out_err(out_err)
   );

   task automatic chk(input string req, input string what,
                      input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   function automatic logic [63:0] model(input logic [7:0] op, input logic [63:0] a,
                                         input logic [63:0] b, output logic err);
      err = 1'b0;
      case (op)
         8'h00: return a;
         8'h01: return ~a;
         8'h04: return a & b;
         8'h05: return a | b;
         8'h06: return a ^ b;
         8'h02, 8'h10: return a << b[31:0];
         8'h11: return a >> b[31:0];
         8'h03: return 64'($signed(a) >>> b[31:0]);
         default: begin
            err = 1'b1;
            return 64'h0;
         end
      endcase
   endfunction

   // drive one request at a falling edge, sample the registered result one cycle later
   task automatic run_op(input string req, input logic [7:0] op,
                         input logic [63:0] a, input logic [63:0] b);
      logic [63:0] exp;
      logic        e_err;
      exp = model(op, a, b, e_err);
      @(negedge clk);
      in_valid = 1'b1;
      in_op = op;
      {a_hi, a_lo} = a;
      {b_hi, b_lo} = b;
      @(negedge clk);
      in_valid = 1'b0;
      chk(req, "result", {out_hi, out_lo}, exp);
      chk(req, "err", {63'd0, out_err}, {63'd0, e_err});
      chk("R2", "valid", {63'd0, out_valid}, 64'd1);
   endtask

   task automatic t_reset;
      chk("R1", "valid in reset", {63'd0, out_valid}, 64'd0);
      chk("R1", "data in reset", {out_hi, out_lo}, 64'd0);
      chk("R1", "err in reset", {63'd0, out_err}, 64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "valid after reset", {63'd0, out_valid}, 64'd0);
      chk("R1", "data after reset", {out_hi, out_lo}, 64'd0);
   endtask

   task automatic t_logic;
      run_op("R3", 8'h04, 64'hF0F0_1234_FFFF_0000, 64'h0FF0_FFFF_00FF_FFFF);
      run_op("R3", 8'h05, 64'h8000_0000_0000_0001, 64'h0000_0001_8000_0000);
      run_op("R3", 8'h06, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001);
   endtask

   task automatic t_unary;
      run_op("R4", 8'h01, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF);
      run_op("R4", 8'h01, 64'h0123_4567_89AB_CDEF, 64'h0);
      run_op("R4", 8'h00, 64'hDEAD_BEEF_CAFE_F00D, 64'h1111_2222_3333_4444);
   endtask

   task automatic t_counts(input string req, input logic [7:0] op, input logic [63:0] a);
      logic [31:0] cnts[8] = '{32'd0, 32'd1, 32'd31, 32'd32, 32'd33, 32'd63, 32'd64, 32'hFFFF_FFFF};
      foreach (cnts[i]) begin
         string tag;
         tag = (cnts[i] == 0 || cnts[i] == 32) ? "R8" : (cnts[i] >= 64 ? "R9" : req);
         run_op(tag, op, a, {32'h0, cnts[i]});
      end
   endtask

   task automatic t_shift_left;
      t_counts("R5", 8'h10, 64'h8765_4321_F00F_A55A);
      t_counts("R5", 8'h02, 64'h8765_4321_F00F_A55A);
   endtask

   task automatic t_shift_right;
      t_counts("R6", 8'h11, 64'hC000_0003_8000_0001);
      t_counts("R7", 8'h03, 64'hC000_0003_8000_0001);
      t_counts("R7", 8'h03, 64'h7000_0003_8000_0001);
      run_op("R9", 8'h11, 64'hFFFF_FFFF_FFFF_FFFF, {32'h0, 32'h0001_0004});
   endtask

   task automatic t_count_hi_ignored;
      run_op("R10", 8'h10, 64'h0000_0001_8000_0000, {32'hFFFF_FFFF, 32'd4});
      run_op("R10", 8'h03, 64'h8000_0000_0000_0010, {32'h1234_5678, 32'd36});
   endtask

   task automatic t_bad_op;
      run_op("R11", 8'h07, 64'h1234_5678_9ABC_DEF0, 64'h1);
      run_op("R11", 8'hE0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h2);
      run_op("R11", 8'h12, 64'h5555_5555_5555_5555, 64'h3);
   endtask

   task automatic t_hold;
      logic [63:0] held;
      run_op("R12", 8'h01, 64'h0, 64'h0);
      held = {out_hi, out_lo};
      @(negedge clk);
      in_op = 8'h00;
      {a_hi, a_lo} = 64'h1357_9BDF_0246_8ACE;
      @(negedge clk);
      chk("R12", "held data", {out_hi, out_lo}, held);
      chk("R2", "valid low", {63'd0, out_valid}, 64'd0);
      chk("R11", "err low when idle", {63'd0, out_err}, 64'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got hang expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (2) @(negedge clk);
      t_reset();
      t_logic();
      t_unary();
      t_shift_left();
      t_shift_right();
      t_count_hi_ignored();
      t_bad_op();
      t_hold();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule